// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a full-duplex serial master. On each transfer it shifts one word out on `mosi` and samples one word from `miso` on the same generated `sck`. The master alone starts transfers and drives the serial clock. At run time the host chooses:

- the idle clock level (`cpol`),
- whether data is captured on the first or the second edge of each bit (`cpha`),
- the bit order (`lsb_first`),
- the clock division (`presc_sel`).

These settings are taken when a transfer is accepted and hold for the whole word.

The host port is a plain register-style interface. The host places a word on `tx_data` and pulses `start`. `busy` stays high for the transfer. A one-cycle `done` pulse marks the end, and `rx_data` then holds the received word.

The slave-select line has three uses:

- The host can drive it directly from a control bit.
- The core can drive it low for the length of each transfer.
- In core-driven mode, the core can release it through a tri-state enable so another master can share the line.

Top module: `spi_master_core`

## Requirements
- R1: After reset, `busy` and `done` are 0, `sck` equals `cpol`, and with `nss_hw`=1 and `nss_oe`=1 the slave select is high with `nss_en`=1.
- R2: Each transfer sends `tx_data` on `mosi` and, in the same SCK cycles, captures a word from `miso` that appears on `rx_data` when `done` pulses.
- R3: While no transfer runs, `sck` rests at the level of `cpol` (0 = low, 1 = high) and follows a change of `cpol` within two clock cycles, also between transfers.
- R4: With `cpha`=0 both sides capture on the first SCK edge of each bit (odd edges 1,3,… in one-based count). With `cpha`=1 they capture on the second edge. SCK stays still during the setup interval and the closing interval.
- R5: With `lsb_first`=0 bit 7 of the word goes first. With `lsb_first`=1 bit 0 goes first. The same order applies when reassembling `rx_data`.
- R6: `presc_sel`=n gives an SCK half-period of 2^n system clocks, so the SCK period is 2^(n+1) clocks, from 2 (n=0) to 256 (n=7). Code 1 divides by 4.
- R7: With `nss_hw`=0 the slave-select output equals `nss_sw` and `nss_en` is 1, during transfers as well.
- R8: With `nss_hw`=1 and `nss_oe`=1, `nss_o` goes low in the clock cycle after `start` is accepted and stays low while `busy` is 1. The first SCK edge comes at least one half-period later. `nss_o` returns high one half-period after the final edge, together with `done`.
- R9: With `nss_hw`=1 and `nss_oe`=0, `nss_en` is 0, so the line is not driven.
- R10: `done` is high for exactly one cycle. `busy` is 0 in that cycle, and `rx_data` holds the captured word until the next transfer ends.
- R11: A `start` pulse while a transfer runs has no effect: the running word, its settings and the single `done` are unchanged, and no new transfer follows.
- R12: A `start` given in the cycle where `done` is high is accepted and begins the next transfer with the new `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| tx_data | input | DATA_W | Word to transmit |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: capture on first edge, 1: on second edge |
| lsb_first | input | 1 | Bit order select |
| presc_sel | input | SEL_W | Half-period = 2^presc_sel clocks |
| nss_hw | input | 1 | 1: core drives slave select, 0: follows nss_sw |
| nss_oe | input | 1 | Output enable for core-driven slave select |
| nss_sw | input | 1 | Slave-select level in host-driven mode |
| rx_data | output | DATA_W | Last received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_o | output | 1 | Slave-select level |
| nss_en | output | 1 | Tri-state enable for nss_o |

## Verification
The end-of-transfer step and a new `start` can meet in one clock. This happens when the host requests the next word in the very cycle `done` is high. The bench provokes it by driving `start` with a fresh word at the sample point where it first sees `done`. It then judges the second transfer by checking:

- the word the slave model collects,
- the returned `rx_data`,
- a single `done` for each word.

The opposite overlap, a `start` while the shifter is mid-word, is driven too. The bench then confirms that the original word completes untouched and that `busy` stays low afterwards.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_HOLD
  } spi_state_e;
endpackage

// File: rtl/spi_half_timer.sv
// Produces a one-cycle tick every 2^sel clocks while enabled.
module spi_half_timer #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = ~({CNT_W{1'b1}} << sel);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R6: the counter never runs past the selected half-period
  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= lim));
endmodule

// File: rtl/spi_shifter.sv
// Transmit and receive shift registers; bit order handled by reversal at the edges.
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_out,
  input  logic              sample_in,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr, rx_sr, tx_rev, rx_rev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign tx_rev[i] = tx_word[DATA_W-1-i];
    assign rx_rev[i] = rx_sr[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)           tx_sr <= lsb_first ? tx_rev : tx_word;
      else if (shift_out) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (sample_in)      rx_sr <= {rx_sr[DATA_W-2:0], miso};
    end
  end

  assign mosi    = tx_sr[DATA_W-1];
  assign rx_word = lsb_first ? rx_rev : rx_sr;

  // R5: after a load the first bit on the line is the selected end of the word
  assert_first_bit_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> mosi == ($past(lsb_first) ? $past(tx_word[0]) : $past(tx_word[DATA_W-1])));
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [SEL_W-1:0]  presc_sel,
  input  logic              nss_hw,
  input  logic              nss_oe,
  input  logic              nss_sw,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              nss_o,
  output logic              nss_en
);
  import spi_master_pkg::*;

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  spi_state_e        state;
  logic [EDGE_W-1:0] edge_cnt;
  logic              cfg_cpha, cfg_lsb;
  logic [SEL_W-1:0]  cfg_sel;
  logic              sck_q, nss_q, busy_q, done_q;
  logic [DATA_W-1:0] rx_q, rx_word;
  logic              tick, edge_tick, sample_edge, shift_edge, first_or_last;
  logic              accept;

  assign accept        = start && (state == ST_IDLE);
  assign edge_tick     = tick && (state == ST_RUN);
  assign first_or_last = cfg_cpha ? (edge_cnt == '0) : (edge_cnt == LAST_EDGE);
  assign sample_edge   = edge_tick && (edge_cnt[0] == cfg_cpha);
  assign shift_edge    = edge_tick && (edge_cnt[0] != cfg_cpha) && !first_or_last;

  spi_half_timer #(.SEL_W(SEL_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (state != ST_IDLE),
    .sel  (cfg_sel),
    .tick (tick)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .lsb_first (accept ? lsb_first : cfg_lsb),
    .tx_word   (tx_data),
    .shift_out (shift_edge),
    .sample_in (sample_edge),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      cfg_cpha <= 1'b0;
      cfg_lsb  <= 1'b0;
      cfg_sel  <= '0;
      sck_q    <= 1'b0;
      nss_q    <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sck_q <= cpol;
          if (start) begin
            cfg_cpha <= cpha;
            cfg_lsb  <= lsb_first;
            cfg_sel  <= presc_sel;
            edge_cnt <= '0;
            busy_q   <= 1'b1;
            nss_q    <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) state <= ST_RUN;
        ST_RUN: if (tick) begin
          sck_q    <= ~sck_q;
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == LAST_EDGE) state <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          state  <= ST_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          nss_q  <= 1'b1;
          rx_q   <= rx_word;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rx_data = rx_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign nss_o   = nss_hw ? nss_q : nss_sw;
  assign nss_en  = !nss_hw || nss_oe;

  // R10: completion pulse lasts a single cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: busy only falls together with the completion pulse
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  // R3: idle clock level tracks polarity
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> (sck_q == $past(cpol)));

  // R8: core-driven select is held low for the whole transfer
  assert_nss_low_R8: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !nss_q);

  // R4: no clock edge in the setup or closing interval
  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP || state == ST_HOLD) |=> $stable(sck_q));

  // R11: a start during a transfer leaves the captured settings unchanged
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |=> ($stable(cfg_sel) && $stable(cfg_cpha) && $stable(cfg_lsb)));
endmodule

// File: tb/spi_master_core_test.sv
module spi_master_core_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         start = 0, cpol = 0, cpha = 0, lsb = 0;
  logic [2:0]   sel = 3'd1;
  logic         nss_hw = 1, nss_oe = 1, nss_sw = 1;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data;
  logic         busy, done, sck, mosi, miso, nss_o, nss_en;

  int checks = 0, fails = 0;

  spi_master_core #(.DATA_W(W), .SEL_W(3)) uut (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb), .presc_sel(sel),
    .nss_hw(nss_hw), .nss_oe(nss_oe), .nss_sw(nss_sw),
    .rx_data(rx_data), .busy(busy), .done(done), .sck(sck),
    .mosi(mosi), .miso(miso), .nss_o(nss_o), .nss_en(nss_en)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Slave model: shifts on the non-capture edges, captures on the capture edges
  logic [W-1:0] s_tx = '0, s_rx = '0;
  int s_e = 0, s_b = 0;
  assign miso = (s_b < W) ? s_tx[lsb ? s_b : W-1-s_b] : 1'b0;

  task automatic slv_load(input logic [W-1:0] w);
    s_tx = w; s_rx = '0; s_e = 0; s_b = 0;
  endtask

  always @(sck) begin
    if (busy) begin
      if ((s_e % 2) == int'(cpha)) s_rx = lsb ? {mosi, s_rx[W-1:1]} : {s_rx[W-2:0], mosi};
      else if (!(cpha && s_e == 0)) s_b = s_b + 1;
      s_e = s_e + 1;
    end
  end

  // Monitor: SCK run lengths and select level during transfers
  int run = 0, rmin = 1000, rmax = 0, nss_bad = 0, edges_seen = 0;
  logic psck = 0;
  always @(negedge clk) begin
    if (busy) begin
      if (sck !== psck) begin
        if (edges_seen > 0) begin
          if (run < rmin) rmin = run;
          if (run > rmax) rmax = run;
        end
        edges_seen++;
        run = 1;
      end else run++;
      if (nss_hw && nss_oe && nss_o) nss_bad++;
    end
    psck = sck;
  end

  task automatic mon_clear();
    rmin = 1000; rmax = 0; nss_bad = 0; edges_seen = 0; run = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done seen"}, done, 1);
  endtask

  task automatic launch(input logic [W-1:0] tx, input logic [W-1:0] sw);
    slv_load(sw);
    tx_data = tx;
    mon_clear();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic frame(input logic [W-1:0] tx, input logic [W-1:0] sw,
                       input logic p, input logic h, input logic l, input logic [2:0] s,
                       input string tag);
    @(negedge clk);
    cpol = p; cpha = h; lsb = l; sel = s;
    repeat (3) @(negedge clk);
    launch(tx, sw);
    wait_done(tag);
    chk(rx_data == sw, {tag, " rx_data (R2)"}, rx_data, sw);
    chk(s_rx == tx, {tag, " mosi word (R2)"}, s_rx, tx);
    chk(busy == 0, {tag, " busy low at done (R10)"}, busy, 0);
    chk(edges_seen == 2*W, {tag, " edge count (R4)"}, edges_seen, 2*W);
    @(negedge clk);
    chk(done == 0, {tag, " done one cycle (R10)"}, done, 0);
    chk(sck == p, {tag, " sck idle after frame (R3)"}, sck, p);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
    chk(sck == cpol, "R1 sck idle after reset", sck, cpol);
    chk(nss_o == 1 && nss_en == 1, "R1 select high and driven", {nss_o, nss_en}, 3);
  endtask

  task automatic t_modes();
    frame(8'hA5, 8'h3C, 0, 0, 0, 3'd1, "R4 mode0");
    frame(8'h96, 8'hE1, 0, 1, 0, 3'd1, "R4 mode1");
    frame(8'h5A, 8'h81, 1, 0, 0, 3'd1, "R3 mode2");
    frame(8'h0F, 8'hF0, 1, 1, 0, 3'd1, "R3 mode3");
    chk(rmin == 2 && rmax == 2, "R6 divide-by-4 half period", rmax, 2);
  endtask

  task automatic t_order();
    frame(8'h01, 8'h80, 0, 0, 1, 3'd1, "R5 lsb mode0");
    frame(8'hC8, 8'h13, 1, 1, 1, 3'd0, "R5 lsb mode3");
  endtask

  task automatic t_presc();
    frame(8'h6D, 8'hB2, 0, 0, 0, 3'd0, "R6 sel0");
    chk(rmin == 1 && rmax == 1, "R6 sel0 half period", rmax, 1);
    frame(8'h33, 8'hCC, 0, 1, 0, 3'd3, "R6 sel3");
    chk(rmin == 8 && rmax == 8, "R6 sel3 half period", rmax, 8);
    frame(8'hE7, 8'h18, 1, 0, 0, 3'd7, "R6 sel7");
    chk(rmin == 128 && rmax == 128, "R6 sel7 half period", rmax, 128);
  endtask

  task automatic t_idle_cpol();
    @(negedge clk); cpol = 1;
    repeat (2) @(negedge clk);
    chk(sck == 1, "R3 idle follows cpol=1", sck, 1);
    cpol = 0;
    repeat (2) @(negedge clk);
    chk(sck == 0, "R3 idle follows cpol=0", sck, 0);
  endtask

  task automatic t_hw_nss();
    @(negedge clk); cpol = 0; cpha = 0; lsb = 0; sel = 3'd2; nss_hw = 1; nss_oe = 1;
    @(negedge clk);
    chk(nss_o == 1, "R8 select high before start", nss_o, 1);
    launch(8'h42, 8'h24);
    chk(nss_o == 0 && sck == 0, "R8 select low before first edge", {nss_o, sck}, 0);
    wait_done("R8 hw");
    chk(nss_o == 1, "R8 select high at done", nss_o, 1);
    chk(nss_bad == 0, "R8 select low throughout busy", nss_bad, 0);
  endtask

  task automatic t_sw_nss();
    @(negedge clk); nss_hw = 0; nss_sw = 0;
    @(negedge clk);
    chk(nss_o == 0 && nss_en == 1, "R7 select follows sw=0", {nss_o, nss_en}, 1);
    nss_sw = 1;
    launch(8'h99, 8'h66);
    repeat (5) @(negedge clk);
    chk(nss_o == 1 && busy == 1, "R7 select stays sw=1 during frame", {nss_o, busy}, 3);
    wait_done("R7 sw");
    chk(rx_data == 8'h66, "R7 frame data in sw mode", rx_data, 8'h66);
  endtask

  task automatic t_nss_off();
    @(negedge clk); nss_hw = 1; nss_oe = 0;
    @(negedge clk);
    chk(nss_en == 0, "R9 select released when idle", nss_en, 0);
    launch(8'h11, 8'h22);
    repeat (4) @(negedge clk);
    chk(nss_en == 0, "R9 select released during frame", nss_en, 0);
    wait_done("R9 off");
    nss_oe = 1;
  endtask

  task automatic t_ignore();
    int extra = 0;
    @(negedge clk); cpol = 0; cpha = 1; lsb = 0; sel = 3'd1;
    @(negedge clk);
    launch(8'hA5, 8'h5A);
    repeat (10) @(negedge clk);
    tx_data = 8'h3C; cpha = 0; lsb = 1; start = 1;
    @(negedge clk);
    start = 0; cpha = 1; lsb = 0;
    wait_done("R11 ignore");
    chk(s_rx == 8'hA5, "R11 word unchanged by late start", s_rx, 8'hA5);
    chk(rx_data == 8'h5A, "R11 rx unchanged by late start", rx_data, 8'h5A);
    repeat (6) begin
      @(negedge clk);
      if (busy || done) extra++;
    end
    chk(extra == 0, "R11 no transfer follows ignored start", extra, 0);
  endtask

  task automatic t_b2b();
    @(negedge clk); cpol = 1; cpha = 0; lsb = 0; sel = 3'd0;
    repeat (2) @(negedge clk);
    launch(8'hC3, 8'h7E);
    wait_done("R12 first");
    chk(s_rx == 8'hC3 && rx_data == 8'h7E, "R12 first word", s_rx, 8'hC3);
    slv_load(8'h81);
    tx_data = 8'h4B;
    mon_clear();
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && done == 0, "R12 start in done cycle accepted", {busy, done}, 2);
    wait_done("R12 second");
    chk(s_rx == 8'h4B, "R12 second mosi word", s_rx, 8'h4B);
    chk(rx_data == 8'h81, "R12 second rx word", rx_data, 8'h81);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_modes();
    t_order();
    t_presc();
    t_idle_cpol();
    t_hw_nss();
    t_sw_nss();
    t_nss_off();
    t_ignore();
    t_b2b();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule